// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block performs a masked gather load into a 256-bit destination of 32-bit elements. A start pulse supplies a base address, a signed displacement, a scale code, an index vector, a mask vector and the prior destination vector. Each active lane's address is formed and sent as one read over a valid/ready request channel. The returned word is written into that lane, and the lane's mask element is cleared.

Lanes are visited one at a time in ascending order, with at most one read in flight. A read that returns an error ends the operation with a fault flag and the lane number. The returned mask still marks the faulting lane and every lane above it, so the same gather can be issued again to finish the work. Index vectors hold either eight 32-bit indices or four 64-bit indices. In the 64-bit index mode only four lanes exist, and the upper 128 bits of the result are zero.

Top module: `gather_seq`

## Requirements
- R1: With `qidx`=0 there are eight lanes, and lane j takes its index from bits [32j+31:32j]. With `qidx`=1 there are four lanes, lane j takes its index from bits [64j+63:64j], and bits [255:128] of both `dst_out` and `mask_out` are zero when `done` is raised.
- R2: A lane is active only when bit 32j+31 of `mask_in` is set. Its other mask bits are ignored. A returned mask lane is either all ones or all zeros.
- R3: The request address of lane j is `base` + (sign-extended index shifted left by `scale`, code 0..3 meaning x1, x2, x4, x8) + sign-extended `disp`, keeping only the low AW bits. Odd or unaligned addresses are issued like any other address and never fault.
- R4: An inactive lane issues no request and keeps its prior destination value.
- R5: When no fault occurs, every active lane holds its returned data, and `mask_out` is all zero at `done`.
- R6: When a response has `rsp_err`=1, `done` follows with `fault`=1 and `fault_lane` equal to that lane. No further request is issued. Lanes below it are complete with a zero mask, and the faulting lane and all higher active lanes keep an all-ones mask.
- R7: If any two of `idx_id`, `msk_id` and `dst_id` are equal, or if `addr16`=1, then `done` and `illegal` are raised one cycle after `start`. No request is issued, and `dst_out`/`mask_out` equal `dst_in`/`mask_in`.
- R8: Requests are issued in ascending lane order, and none is issued while a response is still awaited.
- R9: A request that is not accepted keeps `req_valid` high and `req_addr` unchanged.
- R10: After reset, `done`, `req_valid`, `fault` and `illegal` are 0. `done` is a single-cycle pulse.
- R11: A `start` raised while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| qidx | input | 1 | 1: four 64-bit indices; 0: eight 32-bit indices |
| addr16 | input | 1 | 16-bit address size selected (illegal) |
| scale | input | 2 | Index shift amount, 0..3 |
| idx_id | input | IDW | Identifier of the index register |
| msk_id | input | IDW | Identifier of the mask register |
| dst_id | input | IDW | Identifier of the destination register |
| base | input | AW | Base address |
| disp | input | 32 | Signed displacement |
| idx_in | input | 256 | Index vector |
| mask_in | input | 256 | Mask vector |
| dst_in | input | 256 | Prior destination vector |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read data |
| rsp_err | input | 1 | Read error |
| done | output | 1 | Operation finished (one cycle) |
| dst_out | output | 256 | Resulting destination vector |
| mask_out | output | 256 | Resulting mask vector |
| fault | output | 1 | Operation stopped on a read error |
| fault_lane | output | 3 | Lane that returned the error |
| illegal | output | 1 | Operation refused |

## Verification
The bench aims faults at the first lane, at a middle lane and at the last lane. A design that cleared the mask of the faulting lane, or that went on issuing requests after the error, would return the wrong mask or the wrong request count. Junk in the low mask bits, negative indices, odd base addresses and a 64-bit index whose upper bits must be dropped catch a design that tested the wrong mask bit, extended the index without its sign, or let the address overflow into a fault. In 64-bit index mode the upper destination and mask halves are deliberately nonzero on input, and a stray second start in mid-run must not disturb the result.

// File: rtl/gather_seq.sv
module gather_seq #(
  parameter int AW  = 32,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           qidx,
  input  logic           addr16,
  input  logic [1:0]     scale,
  input  logic [IDW-1:0] idx_id,
  input  logic [IDW-1:0] msk_id,
  input  logic [IDW-1:0] dst_id,
  input  logic [AW-1:0]  base,
  input  logic [31:0]    disp,
  input  logic [255:0]   idx_in,
  input  logic [255:0]   mask_in,
  input  logic [255:0]   dst_in,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  input  logic           rsp_valid,
  input  logic [31:0]    rsp_data,
  input  logic           rsp_err,
  output logic           done,
  output logic [255:0]   dst_out,
  output logic [255:0]   mask_out,
  output logic           fault,
  output logic [2:0]     fault_lane,
  output logic           illegal
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_END} st_t;

  st_t          st;
  logic [2:0]   lane;
  logic         q_r;
  logic [1:0]   sc_r;
  logic [AW-1:0] base_r;
  logic [31:0]  disp_r;
  logic [255:0] idx_r, msk_r, dst_r;

  wire bad = (idx_id == msk_id) || (idx_id == dst_id) || (msk_id == dst_id) || addr16;

  wire [63:0] ix_d = {{32{idx_r[lane*32+31]}}, idx_r[lane*32 +: 32]};
  wire [63:0] ix_q = idx_r[lane[1:0]*64 +: 64];
  wire [63:0] six  = q_r ? ix_q : ix_d;
  wire [63:0] sum  = 64'(base_r) + (six << sc_r) + {{32{disp_r[31]}}, disp_r};

  wire act  = msk_r[lane*32+31];
  wire last = lane == (q_r ? 3'd3 : 3'd7);

  assign req_valid = (st == S_ISSUE) && act;
  assign req_addr  = sum[AW-1:0];
  assign dst_out   = dst_r;
  assign mask_out  = msk_r;

  function automatic logic [255:0] norm(input logic [255:0] m, input logic q);
    logic [255:0] r;
    for (int j = 0; j < 8; j++)
      r[j*32 +: 32] = (q && j >= 4) ? 32'h0 : {32{m[j*32+31]}};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; lane <= '0; q_r <= 1'b0; sc_r <= '0;
      base_r <= '0; disp_r <= '0; idx_r <= '0; msk_r <= '0; dst_r <= '0;
      done <= 1'b0; fault <= 1'b0; fault_lane <= '0; illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fault   <= 1'b0;
          illegal <= 1'b0;
          if (bad) begin
            illegal <= 1'b1;
            done    <= 1'b1;
            dst_r   <= dst_in;
            msk_r   <= mask_in;
          end else begin
            q_r    <= qidx;
            sc_r   <= scale;
            base_r <= base;
            disp_r <= disp;
            idx_r  <= idx_in;
            msk_r  <= norm(mask_in, qidx);
            dst_r  <= qidx ? {128'h0, dst_in[127:0]} : dst_in;
            lane   <= '0;
            st     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!act) begin
            if (last) st <= S_END;
            else lane <= lane + 3'd1;
          end else if (req_ready) st <= S_WAIT;
        end
        S_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            fault      <= 1'b1;
            fault_lane <= lane;
            st         <= S_END;
          end else begin
            dst_r[lane*32 +: 32] <= rsp_data;
            msk_r[lane*32 +: 32] <= 32'h0;
            if (last) st <= S_END;
            else begin
              lane <= lane + 3'd1;
              st   <= S_ISSUE;
            end
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          done,
  input logic          fault,
  input logic          illegal,
  input logic [2:0]    fault_lane,
  input logic [255:0]  mask_out,
  input logic [255:0]  dst_out,
  input logic          q_r
);
  logic waiting;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waiting <= 1'b0;
    else if (req_valid && req_ready) waiting <= 1'b1;
    else if (rsp_valid) waiting <= 1'b0;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !req_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  illegal_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> !fault);

  // R6
  fault_mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> mask_out[fault_lane*32+31]);

  // R5
  clean_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !illegal |-> mask_out == 256'h0);

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && q_r |-> dst_out[255:128] == 128'h0 && mask_out[255:128] == 128'h0);
endmodule

bind gather_seq gather_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .done(done), .fault(fault),
  .illegal(illegal), .fault_lane(fault_lane), .mask_out(mask_out),
  .dst_out(dst_out), .q_r(q_r)
);

// File: tb/gather_seq_bench.sv
module gather_seq_bench;
  localparam int PER = 10;
  localparam int AW  = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, qidx = 1'b0, addr16 = 1'b0;
  logic [1:0] scale = '0;
  logic [3:0] idx_id = 4'd1, msk_id = 4'd2, dst_id = 4'd3;
  logic [AW-1:0] base = '0;
  logic [31:0] disp = '0;
  logic [255:0] idx_in = '0, mask_in = '0, dst_in = '0;
  logic req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_data = '0;
  logic done, fault, illegal;
  logic [2:0] fault_lane;
  logic [255:0] dst_out, mask_out;

  gather_seq #(.AW(AW), .IDW(4)) u_gather_seq (.*);

  always #(PER/2) clk = ~clk;

  int tests = 0, fails = 0;

  // behavioural memory with error injection and a stalling request channel
  logic [31:0] log_a [8];
  int nreq = 0;
  logic pend = 1'b0;
  logic [AW-1:0] paddr = '0, flt_addr = '0;
  logic flt_en = 1'b0;
  logic [3:0] rcnt = '0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  always @(posedge clk) begin
    rcnt <= rcnt + 4'd1;
    req_ready <= (rcnt[1:0] != 2'd3);
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (nreq < 8) log_a[nreq] <= req_addr;
      nreq <= nreq + 1;
      pend <= 1'b1;
      paddr <= req_addr;
    end
    if (pend) begin
      pend <= 1'b0;
      rsp_valid <= 1'b1;
      rsp_data <= memf(paddr);
      rsp_err <= flt_en && (paddr == flt_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input bit q, input logic [1:0] sc,
      input logic [31:0] b, input logic [31:0] d, input logic [255:0] ix, input int j);
    logic [63:0] s, t;
    s = q ? ix[j*64 +: 64] : {{32{ix[j*32+31]}}, ix[j*32 +: 32]};
    t = {32'h0, b} + (s << sc) + {{32{d[31]}}, d};
    return t[31:0];
  endfunction

  task automatic run_case(input bit q, input logic [1:0] sc, input logic [31:0] b,
      input logic [31:0] d, input logic [255:0] ix, input logic [255:0] m,
      input logic [255:0] dv, input int fpick, input bit poke, input string tag);
    logic [255:0] em, ed;
    logic [31:0] ea [8];
    int ne, nl, el, cyc;
    bit ef, ok;
    nl = q ? 4 : 8;
    flt_en = 1'b0;
    if (fpick >= 0 && fpick < nl && m[fpick*32+31]) begin
      flt_en = 1'b1;
      flt_addr = addr_of(q, sc, b, d, ix, fpick);
    end
    ed = dv;
    if (q) ed[255:128] = '0;
    em = '0;
    for (int j = 0; j < nl; j++) em[j*32 +: 32] = {32{m[j*32+31]}};
    ne = 0; ef = 0; el = 0;
    for (int j = 0; j < nl; j++) begin
      if (!ef && em[j*32+31]) begin
        ea[ne] = addr_of(q, sc, b, d, ix, j);
        if (flt_en && ea[ne] == flt_addr) begin
          ef = 1; el = j;
        end else begin
          ed[j*32 +: 32] = memf(ea[ne]);
          em[j*32 +: 32] = '0;
        end
        ne++;
      end
    end
    @(negedge clk);
    nreq = 0;
    qidx = q; scale = sc; base = b; disp = d; idx_in = ix; mask_in = m; dst_in = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      if (poke && cyc == 2) begin start = 1'b1; dst_in = ~dv; mask_in = ~m; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R10", {tag, " done seen"}, 256'(done), 256'(1));
    chk(dst_out == ed, ef ? "R6" : (q ? "R1" : "R5"), {tag, " dst"}, dst_out, ed);
    chk(mask_out == em, ef ? "R6" : "R2", {tag, " mask"}, mask_out, em);
    chk(fault == ef && (!ef || fault_lane == 3'(el)), "R6", {tag, " fault/lane"},
        {fault, fault_lane}, {ef, 3'(el)});
    chk(illegal == 1'b0, "R7", {tag, " not illegal"}, 256'(illegal), 256'(0));
    ok = (nreq == ne);
    for (int k = 0; k < 8; k++) if (k < ne && ok && log_a[k] != ea[k]) ok = 0;
    chk(ok, poke ? "R11" : "R8", {tag, " request count/order (R3 R4)"}, 256'(nreq), 256'(ne));
  endtask

  task automatic run_illegal(input string tag);
    int cyc;
    @(negedge clk);
    nreq = 0;
    mask_in = {8{32'h8000_0001}}; dst_in = {8{32'hCAFE_0000}}; qidx = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && illegal && !fault, "R7", {tag, " flags one cycle after start"},
        {done, illegal, fault}, 3'b110);
    chk(dst_out == dst_in && mask_out == mask_in, "R7", {tag, " vectors unchanged"},
        dst_out ^ dst_in, 256'h0);
    for (cyc = 0; cyc < 6; cyc++) @(negedge clk);
    chk(nreq == 0, "R7", {tag, " no requests"}, 256'(nreq), 256'h0);
  endtask

  // qidx, scale[1:0], lane mask[7:0], fault lane[3:0] (15 = none)
  localparam logic [14:0] TV [10] = '{
    {1'b0, 2'd2, 8'hFF, 4'd15}, {1'b0, 2'd0, 8'hA5, 4'd15},
    {1'b0, 2'd3, 8'h00, 4'd15}, {1'b1, 2'd3, 8'h0F, 4'd15},
    {1'b1, 2'd1, 8'hF5, 4'd15}, {1'b0, 2'd2, 8'hFF, 4'd0},
    {1'b0, 2'd1, 8'hFF, 4'd4},  {1'b0, 2'd2, 8'hFE, 4'd7},
    {1'b1, 2'd2, 8'h0F, 4'd2},  {1'b0, 2'd0, 8'h3C, 4'd3}
  };

  initial begin
    #(PER * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [255:0] ix, m, dv;
    repeat (3) @(negedge clk);
    chk(!done && !req_valid && !fault && !illegal, "R10", "reset state",
        {done, req_valid, fault, illegal}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !req_valid, "R10", "idle after reset", {done, req_valid}, 2'b0);

    foreach (TV[t]) begin
      for (int j = 0; j < 8; j++) begin
        ix[j*32 +: 32] = 32'(j * 37 - 100 + t * 3);
        m[j*32 +: 32]  = {TV[t][4+j], 31'(j * 5 + t)};
        dv[j*32 +: 32] = 32'hD000_0000 + 32'(j * 16 + t);
      end
      if (TV[t][14]) for (int j = 0; j < 4; j++) ix[j*64 +: 64] = 64'(j * 9 - 20 + t);
      run_case(TV[t][14], TV[t][13:12], 32'h0001_0003 + 32'(t), 32'(-7 + t), ix, m, dv,
               TV[t][3:0] == 4'd15 ? -1 : int'(TV[t][3:0]), 1'b0, $sformatf("vec%0d", t));
    end

    for (int r = 0; r < 20; r++) begin
      for (int j = 0; j < 8; j++) begin
        ix[j*32 +: 32] = $urandom;
        m[j*32 +: 32]  = $urandom;
        dv[j*32 +: 32] = $urandom;
      end
      run_case(r[0], 2'($urandom), $urandom, $urandom, ix, m, dv,
               int'($urandom % 10) - 1, 1'b0, $sformatf("rand%0d", r));
    end

    // R3: 64-bit index whose upper bits lie above the address width
    ix = '0;
    ix[63:0] = 64'h1234_0000_0000_0004;
    ix[127:64] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_case(1'b1, 2'd3, 32'hFFFF_FFF1, 32'h0000_0010, ix, {8{32'h8000_0000}},
             {8{32'h1111_1111}}, -1, 1'b0, "R3 truncation");

    // R11: second start while busy
    run_case(1'b0, 2'd2, 32'h0000_2000, 32'd4, {8{32'h0000_0010}}, {8{32'h8000_0000}},
             {8{32'h2222_2222}}, -1, 1'b1, "R11 busy start");

    idx_id = 4'd2; msk_id = 4'd2; dst_id = 4'd3;
    run_illegal("R7 ids equal");
    idx_id = 4'd1; msk_id = 4'd2; dst_id = 4'd1;
    run_illegal("R7 idx=dst");
    idx_id = 4'd1; dst_id = 4'd3; addr16 = 1'b1;
    run_illegal("R7 addr16");
    addr16 = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule